// File: doc/BRIEF.md
# Aperture Page Remapping Table

The block remaps a fixed, page-granular window of I/O address space onto physical memory. Software fills a table of page entries through a small register interface. A lookup port then takes addresses inside the window and returns, one clock later, a physical address built from the selected entry's frame number and the untouched page offset. An unmapped page, an address outside the window, or a table that is switched off all give a fault instead of an address.

Entries are reached indirectly. Software writes a page-aligned byte address from the window into a select register, then reads or writes a data register that stands for the entry under that address. One global enable bit gates every translation. Software is expected to clear every entry before it sets that bit.

The lookup side is a valid/ready stream. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. While `resp_valid` is high and `resp_ready` is low, the response holds steady and no new request is taken.

Top module: `aperture_remap`

## Requirements
- R1: After reset the enable bit, the select register and every entry are zero: the registers read back 0, `resp_valid` is 0 and `req_ready` is 1.
- R2: Register offset 0x24 is the enable. Bit 0 of a write turns translation on (1) or off (0). A read returns the enable in bit 0 and zeros above it.
- R3: Register offset 0x28 is the select register. It holds the full 32-bit byte address last written to it and reads back that value.
- R4: When the select address lies in the window, a write to offset 0x2C stores the entry for page (select − base) >> 12. A read of 0x2C returns that entry with bits 31:12 as written and bits 11:0 as zero. Consecutive entries are 4096 bytes apart.
- R5: When the select address lies outside the window, writes to 0x2C leave every entry unchanged and reads of 0x2C return 0.
- R6: An accepted lookup of an address in the window, to an entry whose bit 31 (valid) is set while translation is enabled, produces `resp_valid` one clock later with `resp_fault` = 0 and `resp_paddr` = {entry[30:12], addr[11:0]}.
- R7: A lookup of an entry whose bit 31 is clear returns `resp_fault` = 1 and `resp_paddr` = 0.
- R8: A lookup of an address below the base, or at or above base + PAGES × 4096, faults with `resp_paddr` = 0.
- R9: While the enable bit is 0, every lookup faults, including those to valid entries.
- R10: While `resp_valid` is 1 and `resp_ready` is 0, `req_ready` is 0 and the response stays unchanged. The next request is taken in the cycle `resp_ready` returns to 1.
- R11: Offsets other than 0x24, 0x28 and 0x2C read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid when reg_rvalid is high |
| reg_rvalid | output | 1 | High one clock after a read strobe |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_addr | input | 32 | Address to translate |
| resp_valid | output | 1 | Lookup response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_paddr | output | 31 | Translated physical address, zero on fault |
| resp_fault | output | 1 | Lookup could not be translated |

## Verification
The bench targets the edges of the window. It uses the first and last pages, the byte just below the base and the first byte past the end. A wrong bound or a wrapped subtraction there would translate an address that must fault. It points the select register outside the window and writes the data register. A design that indexes by the low bits regardless would corrupt a live entry, and the bench detects this by reading that entry back afterwards. It also holds `resp_ready` low while a second request waits. A design that overwrites or drops the response under back-pressure would show the second result early or lose the first.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int DATA_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int FRAME_W    = DATA_W - 1 - PAGE_SHIFT;
  localparam int PA_W       = FRAME_W + PAGE_SHIFT;
  localparam int REG_AW     = 8;

  localparam logic [REG_AW-1:0] OFF_ENABLE = 8'h24;
  localparam logic [REG_AW-1:0] OFF_SELECT = 8'h28;
  localparam logic [REG_AW-1:0] OFF_DATA   = 8'h2C;

  typedef struct packed {
    logic               valid;
    logic [FRAME_W-1:0] frame;
  } entry_t;
endpackage

// File: rtl/aper_window.sv
module aper_window #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] BASE       = 32'h5800_0000,
  parameter int          PAGES      = 32,
  parameter int          PAGE_SHIFT = 12,
  localparam int         IDX_W      = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(PAGES) << PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] BASE_A = BASE[ADDR_W-1:0];

  logic [ADDR_W-1:0] off;

  always_comb begin
    off = addr - BASE_A;
    hit = (addr >= BASE_A) && ({1'b0, off} < SPAN);
    idx = off[PAGE_SHIFT +: IDX_W];
  end
endmodule

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter logic [31:0] BASE  = 32'h5800_0000,
  parameter int          PAGES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              en,
  output entry_t            tbl [PAGES]
);
  localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1;

  logic [DATA_W-1:0] sel_q;
  logic              sel_hit;
  logic [IDX_W-1:0]  sel_idx;
  logic [DATA_W-1:0] rd_mux;

  aper_window #(
    .ADDR_W(DATA_W), .BASE(BASE), .PAGES(PAGES), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_sel_win (
    .addr(sel_q), .hit(sel_hit), .idx(sel_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      sel_q <= '0;
      for (int i = 0; i < PAGES; i++) tbl[i] <= '0;
    end else if (reg_wr_en) begin
      case (reg_addr)
        OFF_ENABLE: en    <= reg_wdata[0];
        OFF_SELECT: sel_q <= reg_wdata;
        OFF_DATA:   if (sel_hit) tbl[sel_idx] <= reg_wdata[DATA_W-1:PAGE_SHIFT];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_ENABLE: rd_mux = {{(DATA_W-1){1'b0}}, en};
      OFF_SELECT: rd_mux = sel_q;
      OFF_DATA:   rd_mux = sel_hit ? {tbl[sel_idx], {PAGE_SHIFT{1'b0}}} : '0;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd_en;
      if (reg_rd_en) reg_rdata <= rd_mux;
    end
  end

  assert_enable_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFF_ENABLE) |=> (en == $past(reg_wdata[0])));

  assert_select_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr == OFF_SELECT && !reg_wr_en) |=> (reg_rdata == sel_q));

  assert_unmapped_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && reg_addr != OFF_ENABLE && reg_addr != OFF_SELECT && reg_addr != OFF_DATA)
      |=> (reg_rdata == '0));
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup
  import remap_pkg::*;
#(
  parameter logic [31:0] BASE  = 32'h5800_0000,
  parameter int          PAGES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  entry_t            tbl [PAGES],
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              resp_fault
);
  localparam int IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1;

  logic             hit;
  logic [IDX_W-1:0] idx;
  entry_t           ent;
  logic             ok;
  logic [PA_W-1:0]  pa_n;
  logic             fire;

  aper_window #(
    .ADDR_W(DATA_W), .BASE(BASE), .PAGES(PAGES), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_req_win (
    .addr(req_addr), .hit(hit), .idx(idx)
  );

  always_comb begin
    ent       = hit ? tbl[idx] : '0;
    ok        = en && hit && ent.valid;
    pa_n      = ok ? {ent.frame, req_addr[PAGE_SHIFT-1:0]} : '0;
    req_ready = !resp_valid || resp_ready;
    fire      = req_valid && req_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_paddr <= '0;
      resp_fault <= 1'b0;
    end else if (fire) begin
      resp_valid <= 1'b1;
      resp_paddr <= pa_n;
      resp_fault <= !ok;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr) && $stable(resp_fault)));

  assert_fault_no_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_paddr == '0));

  assert_disabled_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !en) |=> (resp_valid && resp_fault));
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import remap_pkg::*;
#(
  parameter logic [31:0] BASE  = 32'h5800_0000,
  parameter int          PAGES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rvalid,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        resp_valid,
  input  logic        resp_ready,
  output logic [30:0] resp_paddr,
  output logic        resp_fault
);
  logic   en;
  entry_t tbl [PAGES];

  remap_regs #(.BASE(BASE), .PAGES(PAGES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .en(en), .tbl(tbl)
  );

  remap_lookup #(.BASE(BASE), .PAGES(PAGES)) u_lookup (
    .clk(clk), .rst_n(rst_n), .en(en), .tbl(tbl),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_paddr(resp_paddr), .resp_fault(resp_fault)
  );
endmodule

// File: tb/tb_aperture_remap.sv
module tb_aperture_remap;
  localparam logic [31:0] BASE  = 32'h5800_0000;
  localparam int          PAGES = 32;
  localparam longint      SPAN  = longint'(PAGES) * 4096;
  localparam logic [7:0]  O_EN  = 8'h24, O_SEL = 8'h28, O_DAT = 8'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;
  logic req_valid = 0, resp_ready = 1;
  logic req_ready, resp_valid, resp_fault;
  logic [31:0] req_addr = 0;
  logic [30:0] resp_paddr;

  int errors = 0, checks = 0;
  logic [31:0] m_tbl [PAGES];
  logic        m_en = 0;
  logic [31:0] m_sel = 0;

  always #4 clk = ~clk;

  aperture_remap #(.BASE(BASE), .PAGES(PAGES)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit in_win(logic [31:0] a);
    return (a >= BASE) && (longint'(a - BASE) < SPAN);
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] off);
    if (off == O_EN) return {31'b0, m_en};
    if (off == O_SEL) return m_sel;
    if (off == O_DAT) return in_win(m_sel) ? m_tbl[(m_sel - BASE) >> 12] : 32'h0;
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_lookup(logic [31:0] a);
    logic [31:0] e;
    if (!m_en || !in_win(a)) return 32'h8000_0000;
    e = m_tbl[(a - BASE) >> 12];
    if (!e[31]) return 32'h8000_0000;
    return {1'b0, e[30:12], a[11:0]};
  endfunction

  task automatic wr(logic [7:0] off, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
    if (off == O_EN) m_en = d[0];
    else if (off == O_SEL) m_sel = d;
    else if (off == O_DAT && in_win(m_sel)) m_tbl[(m_sel - BASE) >> 12] = d & 32'hFFFF_F000;
  endtask

  task automatic rd(string req, logic [7:0] off);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = off;
    @(negedge clk);
    reg_rd_en = 0;
    chk(req, {31'b0, reg_rvalid}, 32'h1);
    chk(req, reg_rdata, exp_read(off));
  endtask

  task automatic look(string req, logic [31:0] a);
    logic [31:0] e;
    e = exp_lookup(a);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(req, {31'b0, resp_valid}, 32'h1);
    chk(req, {resp_fault, resp_paddr}, e);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < PAGES; i++) m_tbl[i] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 resp_valid", {31'b0, resp_valid}, 0);
    chk("R1 req_ready", {31'b0, req_ready}, 1);
    rd("R1 enable", O_EN);
    rd("R1 select", O_SEL);
    rd("R1 data", O_DAT);
    // R11 unmapped offsets
    wr(8'h10, 32'hFFFF_FFFF);
    rd("R11 unmapped read", 8'h10);
    rd("R11 enable unchanged", O_EN);
    // R9 disabled lookups fault
    look("R9 disabled", BASE + 32'h10);
    // clear and enable: R2, R3
    for (int p = 0; p < PAGES; p++) begin
      wr(O_SEL, BASE + p * 4096); wr(O_DAT, 0);
    end
    wr(O_EN, 32'h1);
    rd("R2 enable set", O_EN);
    wr(O_SEL, BASE + 3 * 4096 + 32'h5);
    rd("R3 select readback", O_SEL);
    // R4 store and read back
    wr(O_DAT, 32'h8001_2ABC);
    rd("R4 entry readback", O_DAT);
    look("R6 mapped page 3", BASE + 3 * 4096 + 32'h123);
    look("R7 unmapped page 4", BASE + 4 * 4096);
    wr(O_SEL, BASE); wr(O_DAT, 32'h8000_0000 | 32'h7FFF_F000);
    wr(O_SEL, BASE + (PAGES - 1) * 4096); wr(O_DAT, 32'h8005_5000);
    look("R6 first page", BASE);
    look("R6 last byte", BASE + 32'(SPAN) - 1);
    look("R8 below base", BASE - 1);
    look("R8 past end", BASE + 32'(SPAN));
    wr(O_SEL, BASE + 5 * 4096); wr(O_DAT, 32'h0000_9000);
    look("R7 valid clear", BASE + 5 * 4096 + 32'h44);
    // R5 select outside the window
    wr(O_SEL, BASE + 32'(SPAN));
    wr(O_DAT, 32'hFFFF_FFFF);
    rd("R5 read outside", O_DAT);
    wr(O_SEL, BASE - 4096);
    wr(O_DAT, 32'hFFFF_FFFF);
    wr(O_SEL, BASE + (PAGES - 1) * 4096);
    rd("R5 last entry intact", O_DAT);
    wr(O_SEL, BASE);
    rd("R5 first entry intact", O_DAT);
    // R10 back-pressure
    begin
      logic [31:0] ea, eb;
      ea = exp_lookup(BASE + 3 * 4096 + 32'h7);
      eb = exp_lookup(BASE + 32'h9);
      @(negedge clk);
      resp_ready = 0; req_valid = 1; req_addr = BASE + 3 * 4096 + 32'h7;
      @(negedge clk);
      req_addr = BASE + 32'h9;
      chk("R10 ready low", {31'b0, req_ready}, 0);
      chk("R10 first resp", {resp_fault, resp_paddr}, ea);
      @(negedge clk);
      @(negedge clk);
      chk("R10 held valid", {31'b0, resp_valid}, 1);
      chk("R10 held data", {resp_fault, resp_paddr}, ea);
      resp_ready = 1;
      @(negedge clk);
      req_valid = 0;
      chk("R10 second resp", {resp_fault, resp_paddr}, eb);
      @(negedge clk);
      chk("R10 drained", {31'b0, resp_valid}, 0);
    end
    // R9 disable with mapped entries
    wr(O_EN, 32'h0);
    look("R9 mapped but disabled", BASE + 3 * 4096);
    wr(O_EN, 32'h1);
    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [31:0] a;
      op = $urandom % 10;
      if (op < 3) begin
        wr(O_SEL, BASE + ($urandom % PAGES) * 4096); wr(O_DAT, $urandom);
      end else if (op == 3) begin
        wr(O_SEL, $urandom); wr(O_DAT, $urandom);
        rd("R5 random select", O_DAT);
      end else if (op == 4) begin
        rd("R4 random read", O_DAT);
      end else if (op == 5) begin
        wr(O_EN, {31'b0, ($urandom % 4) != 0});
      end else begin
        if ($urandom % 5 == 0) a = $urandom;
        else a = BASE + 32'($urandom % SPAN);
        look("R6 random lookup", a);
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule